// File: doc/BRIEF.md
# Power Island Switch Sequencer

This block brings one switchable power island up and down through a single control register. On a power-on request it closes the island's power switch at the lowest inrush-current setting. If power-good does not arrive within a fixed window, it moves to the next higher setting. Once power-good is seen, it releases electrical isolation, runs a memory-repair handshake with the island and finally releases functional isolation. A power-off request undoes these steps one per clock: functional isolation first, then electrical isolation, then the switch. If the island is already switched on, a power-on request completes at once and changes nothing.

Each failure path unwinds in stages and raises a one-cycle error pulse. If power-good never appears at the highest inrush setting, the switch opens. If memory repair times out, isolation is restored first and the switch opens on the next cycle. Software can also read and write the control fields directly. A write is accepted only when its upper byte holds the key value 0x5A, and only while no sequence is running.

Top module: `pds_switch_seq`

## Requirements
- R1: After reset every control field is 0, so all island outputs, `done_o` and `error_o` are low and `rd_data` reads 0 while both status inputs are low.
- R2: `rd_data` bit map: 0 switch on, 1 power-good input, 2 electrical isolation released, 3 repair request, 4 repair-done input, 5 functional isolation released, 12 request enable, 14:13 inrush code. All other bits read 0, the upper byte included.
- R3: A register write changes the control fields only if `wr_data[31:24]` equals 0x5A. Any other key value is dropped without effect.
- R4: A register write that arrives while a sequence is running is dropped.
- R5: `on_req` and `off_req` are ignored while the enable bit (12) is 0. If both are high in the same idle cycle, the power-on request wins.
- R6: A power-on request while the switch bit is already 1 gives a `done_o` pulse on the next cycle and leaves every field unchanged.
- R7: Power-on sets the switch with inrush code 0. Each code is held for RAMP_WAIT cycles without power-good, and the code then steps up by one, to at most code 3 (3.5, 5, 10, 20 mA for codes 0 to 3).
- R8: Power-good during the ramp releases electrical isolation on the next edge. The repair request is raised one cycle later, so exactly one cycle has isolation released without the repair request.
- R9: Repair-done releases functional isolation and pulses `done_o` on the same edge.
- R10: If code 3 runs out its window without power-good, the switch bit and the inrush code clear together with an `error_o` pulse.
- R11: If repair-done is still absent after REPAIR_WAIT cycles, electrical isolation is restored and the repair request dropped. One cycle later the switch and inrush code clear with an `error_o` pulse.
- R12: Power-off clears functional isolation, then electrical isolation (with the repair request), then the switch, on three successive edges. `done_o` pulses with the last step.
- R13: `done_o` and `error_o` are one-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; upper byte is the key |
| rd_data | output | 32 | Register read value, upper byte zero |
| on_req | input | 1 | Power-on request |
| off_req | input | 1 | Power-off request |
| pwr_ok_i | input | 1 | Island power-good status |
| repair_done_i | input | 1 | Island memory-repair complete |
| switch_en_o | output | 1 | Power switch enable |
| inrush_o | output | 2 | Inrush current limit code |
| elec_iso_rel_o | output | 1 | Electrical isolation released |
| mem_repair_o | output | 1 | Memory repair request |
| func_iso_rel_o | output | 1 | Functional isolation released |
| done_o | output | 1 | Sequence finished pulse |
| error_o | output | 1 | Sequence failed pulse |

## Verification
The assertions assume that the island stub raises power-good only while the switch is closed and raises repair-done only while repair is requested. They also assume that requests are single-cycle pulses given while the sequencer is idle. The stimulus drives power-good from the switch and inrush outputs against a chosen threshold code, and drives repair-done from the repair request and a pass/fail flag. Each request is pulsed for one clock, and the bench waits for `done_o` or `error_o` before the next one.

// File: rtl/pds_pkg.sv
package pds_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned KEY_W    = 8;
  localparam int unsigned INRUSH_W = 2;
  localparam logic [KEY_W-1:0] WR_KEY = 8'h5A;
  localparam logic [INRUSH_W-1:0] INRUSH_TOP = '1;

  // bit positions of the control word
  localparam int unsigned B_POWUP  = 0;
  localparam int unsigned B_PGOOD  = 1;
  localparam int unsigned B_ELEC   = 2;
  localparam int unsigned B_REPREQ = 3;
  localparam int unsigned B_REPDN  = 4;
  localparam int unsigned B_FUNC   = 5;
  localparam int unsigned B_ENAB   = 12;
  localparam int unsigned B_INR_LO = 13;

  typedef struct packed {
    logic                enab;
    logic [INRUSH_W-1:0] inrush;
    logic                func_rel;
    logic                memrep;
    logic                elec_rel;
    logic                powup;
  } ctl_t;

  typedef enum logic [2:0] {
    S_IDLE, S_RAMP, S_ELEC, S_REPAIR, S_UNDO, S_OFF_ELEC, S_OFF_PWR
  } seq_state_e;

  function automatic ctl_t word_to_ctl(input logic [REG_W-1:0] w);
    ctl_t c;
    c.enab     = w[B_ENAB];
    c.inrush   = w[B_INR_LO +: INRUSH_W];
    c.func_rel = w[B_FUNC];
    c.memrep   = w[B_REPREQ];
    c.elec_rel = w[B_ELEC];
    c.powup    = w[B_POWUP];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] ctl_to_word(input ctl_t c,
                                                   input logic pgood,
                                                   input logic repdn);
    logic [REG_W-1:0] w;
    w = '0;
    w[B_ENAB]                 = c.enab;
    w[B_INR_LO +: INRUSH_W]   = c.inrush;
    w[B_FUNC]                 = c.func_rel;
    w[B_REPDN]                = repdn;
    w[B_REPREQ]               = c.memrep;
    w[B_ELEC]                 = c.elec_rel;
    w[B_PGOOD]                = pgood;
    w[B_POWUP]                = c.powup;
    return w;
  endfunction
endpackage

// File: rtl/pds_timer.sv
module pds_timer #(
  parameter int unsigned RAMP_WAIT   = 300,
  parameter int unsigned REPAIR_WAIT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic sel_repair,
  output logic expired
);
  localparam int unsigned MAXW = (RAMP_WAIT > REPAIR_WAIT) ? RAMP_WAIT : REPAIR_WAIT;
  localparam int unsigned CW   = $clog2(MAXW + 1);
  localparam logic [CW-1:0] RAMP_INIT = CW'(RAMP_WAIT - 1);
  localparam logic [CW-1:0] REP_INIT  = CW'(REPAIR_WAIT - 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= sel_repair ? REP_INIT : RAMP_INIT;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign expired = run && (cnt == '0);

  // R7
  expire_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> !expired);
endmodule

// File: rtl/pds_ctl_reg.sv
module pds_ctl_reg
  import pds_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             bus_open,
  input  logic             seq_we,
  input  ctl_t             seq_ctl,
  input  logic             pgood,
  input  logic             repdn,
  output ctl_t             ctl,
  output logic [REG_W-1:0] rd_data
);
  logic key_ok;
  assign key_ok = (wr_data[REG_W-1 -: KEY_W] == WR_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         ctl <= '0;
    else if (seq_we)                    ctl <= seq_ctl;
    else if (wr_en && bus_open && key_ok) ctl <= word_to_ctl(wr_data);
  end

  assign rd_data = ctl_to_word(ctl, pgood, repdn);

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_ok && !seq_we) |=> $stable(ctl));
  // R4
  busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !bus_open && !seq_we) |=> $stable(ctl));
endmodule

// File: rtl/pds_seq_fsm.sv
module pds_seq_fsm
  import pds_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic on_req,
  input  logic off_req,
  input  logic pgood,
  input  logic repdn,
  input  logic expired,
  input  ctl_t ctl,
  output logic seq_we,
  output ctl_t seq_ctl,
  output logic tmr_load,
  output logic tmr_sel_repair,
  output logic idle,
  output logic done_o,
  output logic error_o
);
  seq_state_e st, st_n;
  logic done_n, err_n;

  always_comb begin
    st_n           = st;
    seq_ctl        = ctl;
    seq_we         = 1'b0;
    tmr_load       = 1'b0;
    tmr_sel_repair = 1'b0;
    done_n         = 1'b0;
    err_n          = 1'b0;
    case (st)
      S_IDLE: begin
        if (ctl.enab && on_req) begin
          if (ctl.powup) begin
            done_n = 1'b1;
          end else begin
            seq_ctl.powup  = 1'b1;
            seq_ctl.inrush = '0;
            seq_we         = 1'b1;
            tmr_load       = 1'b1;
            st_n           = S_RAMP;
          end
        end else if (ctl.enab && off_req) begin
          seq_ctl.func_rel = 1'b0;
          seq_we           = 1'b1;
          st_n             = S_OFF_ELEC;
        end
      end
      S_RAMP: begin
        if (pgood) begin
          seq_ctl.elec_rel = 1'b1;
          seq_we           = 1'b1;
          st_n             = S_ELEC;
        end else if (expired) begin
          seq_we = 1'b1;
          if (ctl.inrush == INRUSH_TOP) begin
            seq_ctl.powup  = 1'b0;
            seq_ctl.inrush = '0;
            err_n          = 1'b1;
            st_n           = S_IDLE;
          end else begin
            seq_ctl.inrush = ctl.inrush + 1'b1;
            tmr_load       = 1'b1;
          end
        end
      end
      S_ELEC: begin
        seq_ctl.memrep = 1'b1;
        seq_we         = 1'b1;
        tmr_load       = 1'b1;
        tmr_sel_repair = 1'b1;
        st_n           = S_REPAIR;
      end
      S_REPAIR: begin
        if (repdn) begin
          seq_ctl.func_rel = 1'b1;
          seq_we           = 1'b1;
          done_n           = 1'b1;
          st_n             = S_IDLE;
        end else if (expired) begin
          seq_ctl.elec_rel = 1'b0;
          seq_ctl.memrep   = 1'b0;
          seq_we           = 1'b1;
          st_n             = S_UNDO;
        end
      end
      S_UNDO: begin
        seq_ctl.powup  = 1'b0;
        seq_ctl.inrush = '0;
        seq_we         = 1'b1;
        err_n          = 1'b1;
        st_n           = S_IDLE;
      end
      S_OFF_ELEC: begin
        seq_ctl.elec_rel = 1'b0;
        seq_ctl.memrep   = 1'b0;
        seq_we           = 1'b1;
        st_n             = S_OFF_PWR;
      end
      S_OFF_PWR: begin
        seq_ctl.powup = 1'b0;
        seq_we        = 1'b1;
        done_n        = 1'b1;
        st_n          = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      done_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      st      <= st_n;
      done_o  <= done_n;
      error_o <= err_n;
    end
  end

  assign idle = (st == S_IDLE);

  // R13
  done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && error_o));
  // R7
  inrush_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP && $past(st == S_RAMP) && ctl.inrush != $past(ctl.inrush))
      |-> ctl.inrush == $past(ctl.inrush) + 1'b1);
  // R8
  repair_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_REPAIR) |-> (ctl.elec_rel && ctl.powup && ctl.memrep));
  // R10
  error_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error_o |-> (!ctl.powup && !ctl.elec_rel && ctl.inrush == '0));
  // R12
  off_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OFF_PWR) |-> (!ctl.func_rel && !ctl.elec_rel && ctl.powup));
endmodule

// File: rtl/pds_switch_seq.sv
module pds_switch_seq
  import pds_pkg::*;
#(
  parameter int unsigned RAMP_WAIT   = 300,
  parameter int unsigned REPAIR_WAIT = 100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  input  logic        on_req,
  input  logic        off_req,
  input  logic        pwr_ok_i,
  input  logic        repair_done_i,
  output logic        switch_en_o,
  output logic [1:0]  inrush_o,
  output logic        elec_iso_rel_o,
  output logic        mem_repair_o,
  output logic        func_iso_rel_o,
  output logic        done_o,
  output logic        error_o
);
  ctl_t ctl, seq_ctl;
  logic seq_we, tmr_load, tmr_sel, expired, idle;

  pds_ctl_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .bus_open (idle),
    .seq_we   (seq_we),
    .seq_ctl  (seq_ctl),
    .pgood    (pwr_ok_i),
    .repdn    (repair_done_i),
    .ctl      (ctl),
    .rd_data  (rd_data)
  );

  pds_timer #(
    .RAMP_WAIT   (RAMP_WAIT),
    .REPAIR_WAIT (REPAIR_WAIT)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (tmr_load),
    .sel_repair (tmr_sel),
    .expired    (expired)
  );

  pds_seq_fsm u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .on_req         (on_req),
    .off_req        (off_req),
    .pgood          (pwr_ok_i),
    .repdn          (repair_done_i),
    .expired        (expired),
    .ctl            (ctl),
    .seq_we         (seq_we),
    .seq_ctl        (seq_ctl),
    .tmr_load       (tmr_load),
    .tmr_sel_repair (tmr_sel),
    .idle           (idle),
    .done_o         (done_o),
    .error_o        (error_o)
  );

  assign switch_en_o    = ctl.powup;
  assign inrush_o       = ctl.inrush;
  assign elec_iso_rel_o = ctl.elec_rel;
  assign mem_repair_o   = ctl.memrep;
  assign func_iso_rel_o = ctl.func_rel;
endmodule

// File: tb/pds_switch_seq_tb.sv
module pds_switch_seq_tb;
  localparam int RW = 6;
  localparam int PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic on_req = 1'b0, off_req = 1'b0;
  logic pwr_ok_i, repair_done_i;
  logic switch_en_o, elec_iso_rel_o, mem_repair_o, func_iso_rel_o, done_o, error_o;
  logic [1:0] inrush_o;

  logic [2:0] ok_code = 3'd0;
  logic rep_ok = 1'b1;
  int checks = 0, errors = 0;
  int done_cnt = 0, err_cnt = 0, elec_only = 0;
  int hold [4];

  always #5 clk = ~clk;

  assign pwr_ok_i      = switch_en_o && ({1'b0, inrush_o} >= ok_code);
  assign repair_done_i = mem_repair_o && rep_ok;

  pds_switch_seq #(.RAMP_WAIT(RW), .REPAIR_WAIT(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .on_req(on_req), .off_req(off_req), .pwr_ok_i(pwr_ok_i), .repair_done_i(repair_done_i),
    .switch_en_o(switch_en_o), .inrush_o(inrush_o), .elec_iso_rel_o(elec_iso_rel_o),
    .mem_repair_o(mem_repair_o), .func_iso_rel_o(func_iso_rel_o),
    .done_o(done_o), .error_o(error_o)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) done_cnt++;
      if (error_o) err_cnt++;
      if (elec_iso_rel_o && !mem_repair_o) elec_only++;
      if (switch_en_o && !elec_iso_rel_o) hold[inrush_o]++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    done_cnt = 0; err_cnt = 0; elec_only = 0;
    for (int k = 0; k < 4; k++) hold[k] = 0;
  endtask

  task automatic reg_write(input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic on, input logic off);
    @(negedge clk); on_req = on; off_req = off;
    @(negedge clk); on_req = 1'b0; off_req = 1'b0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 200; i++) begin
      if (done_o || error_o) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 outputs", {switch_en_o, inrush_o, elec_iso_rel_o, mem_repair_o,
                       func_iso_rel_o, done_o, error_o}, '0);
  endtask

  task automatic t_password();
    reg_write(32'h11001001);
    chk("R3 bad key dropped", rd_data, 32'h0);
    reg_write(32'h5A001000);
    chk("R2 good key, upper byte zero", rd_data, 32'h0000_1000);
    reg_write(32'hA5000001);
    chk("R3 second bad key dropped", rd_data, 32'h0000_1000);
  endtask

  task automatic t_enable_gate();
    reg_write(32'h5A000000);
    clr_mon();
    pulse(1'b1, 1'b0);
    repeat (20) @(negedge clk);
    chk("R5 disabled request ignored", {switch_en_o, 1'b0}, 2'b00);
    chk("R5 no done when disabled", done_cnt, 0);
  endtask

  task automatic t_power_on();
    reg_write(32'h5A001000);
    ok_code = 3'd2; rep_ok = 1'b1;
    clr_mon();
    pulse(1'b1, 1'b0);
    wait_end();
    chk("R7 code0 hold", hold[0], RW);
    chk("R7 code1 hold", hold[1], RW);
    chk("R8 pgood seen on first code2 cycle", hold[2], 1);
    chk("R8 one cycle iso released before repair", elec_only, 1);
    chk("R9 done once", done_cnt, 1);
    chk("R13 no error", err_cnt, 0);
    chk("R9 final register", rd_data, 32'h0000_503F);
  endtask

  task automatic t_skip();
    clr_mon();
    pulse(1'b1, 1'b0);
    repeat (5) @(negedge clk);
    chk("R6 done once", done_cnt, 1);
    chk("R6 no ramp", hold[0], 0);
    chk("R6 register unchanged", rd_data, 32'h0000_503F);
  endtask

  task automatic t_power_off();
    clr_mon();
    @(negedge clk); off_req = 1'b1;
    @(negedge clk); off_req = 1'b0;
    chk("R12 step1", {func_iso_rel_o, elec_iso_rel_o, switch_en_o, done_o}, 4'b0110);
    @(negedge clk);
    chk("R12 step2", {func_iso_rel_o, elec_iso_rel_o, mem_repair_o, switch_en_o, done_o}, 5'b00010);
    @(negedge clk);
    chk("R12 step3 with done", {switch_en_o, done_o}, 2'b01);
    @(negedge clk);
    chk("R13 done one cycle", done_o, 1'b0);
    chk("R12 register after off", rd_data, 32'h0000_5000);
  endtask

  task automatic t_ramp_fail();
    ok_code = 3'd4;
    clr_mon();
    pulse(1'b1, 1'b0);
    wait_end();
    for (int k = 0; k < 4; k++) chk("R10 each code held full window", hold[k], RW);
    chk("R10 error once", err_cnt, 1);
    chk("R10 switch and code cleared", rd_data, 32'h0000_1000);
  endtask

  task automatic t_repair_timeout();
    ok_code = 3'd1; rep_ok = 1'b0;
    clr_mon();
    pulse(1'b1, 1'b0);
    for (int i = 0; i < 100 && !elec_iso_rel_o; i++) @(negedge clk);
    for (int i = 0; i < 100 && elec_iso_rel_o; i++) @(negedge clk);
    chk("R11 iso restored, switch still on",
        {switch_en_o, mem_repair_o, error_o}, 3'b100);
    @(negedge clk);
    chk("R11 switch off with error", {switch_en_o, inrush_o, error_o}, 4'b0001);
    repeat (2) @(negedge clk);
    chk("R11 register", rd_data, 32'h0000_1000);
    rep_ok = 1'b1;
  endtask

  task automatic t_busy_write();
    ok_code = 3'd3;
    clr_mon();
    pulse(1'b1, 1'b0);
    repeat (3) @(negedge clk);
    reg_write(32'h5A000000);
    wait_end();
    chk("R4 write during sequence dropped", rd_data, 32'h0000_703F);
  endtask

  task automatic t_priority();
    pulse(1'b0, 1'b1);
    wait_end();
    ok_code = 3'd0;
    clr_mon();
    pulse(1'b1, 1'b1);
    wait_end();
    chk("R5 on wins over off", {switch_en_o, func_iso_rel_o}, 2'b11);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    clr_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_password();
    t_enable_gate();
    t_power_on();
    t_skip();
    t_power_off();
    t_ramp_fail();
    t_repair_timeout();
    t_busy_write();
    t_priority();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule